// File: doc/BRIEF.md
# Mode-Gated Pin Function Register

This block is a three-bit control register. It hands a few general-purpose port pins over to bus-control duties. The three duties are:

- a pair of pins that report instruction-queue status,
- a pin that carries the external bus clock,
- a pin that carries the low-byte write strobe.

Whether a write reaches a bit depends on two things: the chip operating mode, and whether any write has already occurred since reset. Some bits take only the first write. Some refuse the first write and take all later ones. One bit takes no writes at all in most modes.

The stored bits are combined with the operating mode and with an external strobe-select input. The result is a set of per-pin select outputs, and the pad logic uses them to choose between GPIO and the bus function. Reads return the stored value at all times.

The operating mode is a 3-bit code. Bit 0 is 1 for normal modes and 0 for special modes. Bits [2:1] give the bus configuration:

| Bits [2:1] | Bus configuration |
|---|---|
| 00 | single-chip |
| 01 | expanded narrow |
| 10 | expanded wide |
| 11 | peripheral |

Peripheral mode is code 110. Code 111 behaves as normal expanded wide.

Top module: `pin_func_reg`

## Requirements
- R1: After a synchronous reset, all three bits read 0 on `rdData`, which shows the stored value at all times: bit 2 is the queue-status enable, bit 1 the clock disable, bit 0 the low-strobe enable.
- R2: In a normal mode (mode[0]=1), the queue-status and low-strobe enables take the first write after reset and ignore every later one.
- R3: In a special mode (mode[0]=0), the queue-status and low-strobe enables ignore the first write after reset and take every later one. Every write pulse counts as a write, whether or not it was accepted.
- R4: The clock disable bit follows the mode:
  - normal single-chip (001): it takes only the first write;
  - special single-chip (000): it takes every write;
  - any other mode: it keeps its value.
- R5: `pipeSel` equals the queue-status enable in the expanded modes (mode[2:1] of 01 or 10, or code 111). It is 0 in single-chip and peripheral modes.
- R6: `eclkSel` is 1 when the clock disable bit is 0, except that in single-chip modes the `strobeSelIn` input must also be 0.
- R7: `eclkIsInput` is 1 only in peripheral mode (110).
- R8: `lstrbSel` equals the low-strobe enable, except that it is forced to 0 in single-chip modes and in normal expanded narrow mode (011).
- R9: `lstrbHoldHigh` is 1 exactly in normal expanded narrow mode (011). This makes the strobe pin an output driving high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write pulse, one per write transaction |
| wrData | input | 3 | Write data, same bit layout as rdData |
| rdData | output | 3 | Stored register value |
| mode | input | 3 | Operating mode code |
| strobeSelIn | input | 1 | External strobe-select bit that gates the clock in single-chip modes |
| pipeSel | output | 1 | Queue-status pins take the bus function |
| eclkSel | output | 1 | Clock pin carries the bus clock |
| eclkIsInput | output | 1 | Clock pin direction is input |
| lstrbSel | output | 1 | Strobe pin carries the low-byte strobe |
| lstrbHoldHigh | output | 1 | Strobe pin is held as an output driving high |

## Verification
A write and the pin decode can land in the same cycle. At that edge the stored bit changes and the select outputs follow it at once, while `strobeSelIn` and the mode are also steering the decode.

The bench provokes this in every one of the eight modes. It issues a series of writes that includes the first one after reset. After each write it samples the read value and the selects with `strobeSelIn` at both levels.

Each sample is judged against a bench model that applies the first-write and mode rules independently of the design.

// File: rtl/pin_func_pkg.sv
package pin_func_pkg;
  localparam int NUM_BITS  = 3;
  localparam int MODE_W    = 3;
  localparam int BIT_LSTRB = 0;
  localparam int BIT_CLKDIS = 1;
  localparam int BIT_PIPE  = 2;

  typedef struct packed {
    logic ldPipe;
    logic ldClk;
    logic ldStrobe;
  } loadStrobes_t;

  function automatic logic isNormal(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction

  function automatic logic isSingle(input logic [MODE_W-1:0] m);
    return m[2:1] == 2'b00;
  endfunction

  function automatic logic isPeriph(input logic [MODE_W-1:0] m);
    return m == 3'b110;
  endfunction

  function automatic logic isExpanded(input logic [MODE_W-1:0] m);
    return !isSingle(m) && !isPeriph(m);
  endfunction

  function automatic logic isNormalNarrow(input logic [MODE_W-1:0] m);
    return m == 3'b011;
  endfunction
endpackage

// File: rtl/pin_func_ctrl.sv
module pin_func_ctrl
  import pin_func_pkg::*;
#(
  parameter int BITS = NUM_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] mode,
  output loadStrobes_t      ld,
  output logic [BITS-1:0]   firstDone
);
  // One tracking flag per bit, set by any write transaction.
  for (genvar i = 0; i < BITS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) firstDone[i] <= 1'b0;
      else if (wrEn) firstDone[i] <= 1'b1;
    end
  end

  logic pipeOk, strobeOk, clkOk;

  always_comb begin
    pipeOk   = isNormal(mode) ? !firstDone[BIT_PIPE]  : firstDone[BIT_PIPE];
    strobeOk = isNormal(mode) ? !firstDone[BIT_LSTRB] : firstDone[BIT_LSTRB];
    unique case (mode)
      3'b001:  clkOk = !firstDone[BIT_CLKDIS];
      3'b000:  clkOk = 1'b1;
      default: clkOk = 1'b0;
    endcase
    ld.ldPipe   = wrEn && pipeOk;
    ld.ldStrobe = wrEn && strobeOk;
    ld.ldClk    = wrEn && clkOk;
  end
endmodule

// File: rtl/pin_func_dp.sv
module pin_func_dp
  import pin_func_pkg::*;
#(
  parameter int BITS = NUM_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  loadStrobes_t      ld,
  input  logic [BITS-1:0]   wrData,
  input  logic [MODE_W-1:0] mode,
  input  logic              strobeSelIn,
  output logic [BITS-1:0]   rdData,
  output logic              pipeSel,
  output logic              eclkSel,
  output logic              eclkIsInput,
  output logic              lstrbSel,
  output logic              lstrbHoldHigh
);
  logic [BITS-1:0] regQ;
  logic [BITS-1:0] loadVec;

  always_comb begin
    loadVec             = '0;
    loadVec[BIT_PIPE]   = ld.ldPipe;
    loadVec[BIT_CLKDIS] = ld.ldClk;
    loadVec[BIT_LSTRB]  = ld.ldStrobe;
  end

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) regQ[i] <= 1'b0;
      else if (loadVec[i]) regQ[i] <= wrData[i];
    end
  end

  assign rdData = regQ;

  always_comb begin
    pipeSel       = regQ[BIT_PIPE] && isExpanded(mode);
    eclkSel       = !regQ[BIT_CLKDIS] && !(isSingle(mode) && strobeSelIn);
    eclkIsInput   = isPeriph(mode);
    lstrbSel      = regQ[BIT_LSTRB] && !isSingle(mode) && !isNormalNarrow(mode);
    lstrbHoldHigh = isNormalNarrow(mode);
  end

  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (rst)
    (isSingle(mode) || isNormalNarrow(mode)) |-> !lstrbSel); // R8
  AST_PIPE_GATED: assert property (@(posedge clk) disable iff (rst)
    !isExpanded(mode) |-> !pipeSel); // R5
endmodule

// File: rtl/pin_func_reg.sv
module pin_func_reg
  import pin_func_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [NUM_BITS-1:0] wrData,
  output logic [NUM_BITS-1:0] rdData,
  input  logic [MODE_W-1:0] mode,
  input  logic              strobeSelIn,
  output logic              pipeSel,
  output logic              eclkSel,
  output logic              eclkIsInput,
  output logic              lstrbSel,
  output logic              lstrbHoldHigh
);
  loadStrobes_t ld;
  logic [NUM_BITS-1:0] firstDone;

  pin_func_ctrl #(.BITS(NUM_BITS)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .mode(mode),
    .ld(ld), .firstDone(firstDone)
  );

  pin_func_dp #(.BITS(NUM_BITS)) i_dp (
    .clk(clk), .rst(rst), .ld(ld), .wrData(wrData), .mode(mode),
    .strobeSelIn(strobeSelIn), .rdData(rdData), .pipeSel(pipeSel),
    .eclkSel(eclkSel), .eclkIsInput(eclkIsInput), .lstrbSel(lstrbSel),
    .lstrbHoldHigh(lstrbHoldHigh)
  );

  AST_NORMAL_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (firstDone[BIT_PIPE] && isNormal(mode)) |=>
      ($stable(rdData[BIT_PIPE]) && $stable(rdData[BIT_LSTRB]))); // R2
  AST_SPECIAL_FIRST_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!firstDone[BIT_LSTRB] && !isNormal(mode)) |=>
      ($stable(rdData[BIT_PIPE]) && $stable(rdData[BIT_LSTRB]))); // R3
  AST_CLK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !isSingle(mode) |=> $stable(rdData[BIT_CLKDIS])); // R4
  AST_CLK_ONCE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b001 && firstDone[BIT_CLKDIS]) |=> $stable(rdData[BIT_CLKDIS])); // R4
endmodule

// File: tb/test_pin_func_reg.sv
`timescale 1ns/1ps
module test_pin_func_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrData = '0;
  logic [2:0] rdData;
  logic [2:0] mode = '0;
  logic strobeSelIn = 1'b0;
  logic pipeSel, eclkSel, eclkIsInput, lstrbSel, lstrbHoldHigh;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_func_reg i_pin_func_reg (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .mode(mode), .strobeSelIn(strobeSelIn), .pipeSel(pipeSel),
    .eclkSel(eclkSel), .eclkIsInput(eclkIsInput), .lstrbSel(lstrbSel),
    .lstrbHoldHigh(lstrbHoldHigh)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d act=%0h exp=%0h", req, mode, act, exp);
    end
  endtask

  task automatic checkPins(input logic [2:0] m, input logic [2:0] r);
    logic single;
    logic periph;
    logic narrowN;
    single  = (m[2:1] == 2'b00);
    periph  = (m == 3'b110);
    narrowN = (m == 3'b011);
    for (int s = 0; s < 2; s++) begin
      strobeSelIn = s[0];
      #1;
      check("R5", {2'b0, pipeSel}, {2'b0, r[2] & !single & !periph});
      check("R6", {2'b0, eclkSel}, {2'b0, !r[1] & !(single & s[0])});
      check("R7", {2'b0, eclkIsInput}, {2'b0, periph});
      check("R8", {2'b0, lstrbSel}, {2'b0, r[0] & !single & !narrowN});
      check("R9", {2'b0, lstrbHoldHigh}, {2'b0, narrowN});
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq [4];
    seq[0] = 3'b111;
    seq[1] = 3'b010;
    seq[2] = 3'b101;
    seq[3] = 3'b000;
    for (int m = 0; m < 8; m++) begin
      logic [2:0] model;
      logic done;
      @(negedge clk);
      mode = m[2:0];
      rst = 1'b1;
      wrEn = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", rdData, 3'b000);
      model = 3'b000;
      done = 1'b0;
      checkPins(mode, model);
      for (int w = 0; w < 4; w++) begin
        logic psOk;
        logic ckOk;
        @(negedge clk);
        wrData = seq[w];
        wrEn = 1'b1;
        psOk = m[0] ? !done : done;
        ckOk = (m == 1) ? !done : (m == 0);
        if (psOk) begin
          model[2] = seq[w][2];
          model[0] = seq[w][0];
        end
        if (ckOk) model[1] = seq[w][1];
        done = 1'b1;
        @(negedge clk);
        wrEn = 1'b0;
        #1;
        if (m[0]) check("R2", {rdData[2], 1'b0, rdData[0]}, {model[2], 1'b0, model[0]});
        else check("R3", {rdData[2], 1'b0, rdData[0]}, {model[2], 1'b0, model[0]});
        check("R4", {2'b0, rdData[1]}, {2'b0, model[1]});
        check("R1", rdData, model);
        checkPins(mode, model);
      end
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule